// File: doc/BRIEF.md
# Pixel-Pair Clock Domain Crossing

This block carries a stream of video pixels from a slow source clock into an unrelated, faster destination clock. A typical pairing is a 27 MHz pixel clock and a 108 MHz system clock. The source side takes one pixel on every source clock edge. It joins each two consecutive pixels into a pair register and flips a toggle line each time a new pair is ready. Each pair therefore stays still for two source clock periods.

The destination side samples the toggle through one flip-flop. A four-state machine then turns every level change of the toggle, rising or falling, into a one-cycle write pulse. That pulse copies the whole pair in one step into a destination register and raises a valid strobe. Only one bit of the state machine looks at the synchronized toggle.

The detection path takes about three destination cycles. Sending pixels two at a time leaves that path enough slack. The block does no rate matching, so the consumer must accept a pair whenever valid rises. Both domains use synchronous, active-high resets, and these are expected to be applied together.

Top module: `pxcPairCross`

## Requirements
- R1: While the destination reset is held, and in the cycles after it is released while the source is still in reset, `dstValid` is 0 and `dstPair` is all zeros.
- R2: Within a delivered pair, the earlier pixel is in the low half `dstPair[PIX_W-1:0]` and the later pixel is in the high half. Pairs are made from source pixels 0 and 1, then 2 and 3, and so on, counted from the first source edge after the source reset is released.
- R3: Each completed pair is delivered exactly once, in source order, with no extra deliveries.
- R4: `dstValid` is high for exactly one destination cycle per pair and is never high in two consecutive destination cycles.
- R5: `dstPair` changes only in a cycle in which `dstValid` is high.
- R6: A pair shows up on the outputs at the third destination rising edge, counting from the first destination rising edge after the source edge that completed the pair. At the falling edge that follows, this is more than 2.5 and less than 3.5 destination periods after that source edge.
- R7: Asserting both resets in the middle of a stream drops any pair still in flight. No stale pulse follows the release. Pairing restarts with the first pixel taken after the source reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcClk | input | 1 | Source pixel clock |
| srcRst | input | 1 | Synchronous active-high reset, source domain |
| srcPix | input | PIX_W | Pixel sampled on each source clock edge |
| dstClk | input | 1 | Destination system clock |
| dstRst | input | 1 | Synchronous active-high reset, destination domain |
| dstPair | output | 2*PIX_W | Last delivered pair; earlier pixel in the low half |
| dstValid | output | 1 | One-cycle strobe, high while a new pair is presented |

## Verification
The source clock starts at a random phase and runs a little faster than a quarter of the destination rate, so the toggle lands at varying points within the destination cycle. This is where a detector that missed one edge direction would drop every other pair, and one that pulsed twice per change would duplicate pairs. Each delivery is compared against a pair predicted from the driven pixels, including its arrival time. Swapped halves, off-by-one pairing or an extra pipeline stage would therefore show up directly. A reset in mid-stream targets stale pairs and bad restart alignment. Checks every cycle between strobes catch a destination register that loads without its enable.

// File: rtl/pxc_pkg.sv
`timescale 1ns/1ps
package pxc_pkg;

  // Edge-detect states; bit 0 is the write pulse, bit 1 tracks the toggle level.
  typedef enum logic [1:0] {
    ST_WAIT_HI  = 2'b00,
    ST_PULSE_UP = 2'b01,
    ST_WAIT_LO  = 2'b10,
    ST_PULSE_DN = 2'b11
  } edgeStateT;

  // Strobes from the destination control to the destination datapath.
  typedef struct packed {
    logic wrPulse;
  } dstStrobeT;

endpackage

// File: rtl/pxcSrcStage.sv
`timescale 1ns/1ps
module pxcSrcStage #(
  parameter int PIX_W  = 8,
  parameter int PAIR_N = 2
) (
  input  logic                      srcClk,
  input  logic                      srcRst,
  input  logic [PIX_W-1:0]          pixIn,
  output logic [PAIR_N*PIX_W-1:0]   pairOut,
  output logic                      pairToggle
);

  localparam int PHASE_W = $clog2(PAIR_N);
  localparam int CNT_W   = PHASE_W + 1;
  localparam int LEAD_N  = PAIR_N - 1;

  logic [CNT_W-1:0]          phaseCnt;
  logic [PIX_W-1:0]          leadStage [LEAD_N];
  logic [PAIR_N*PIX_W-1:0]   pairNext;
  logic                      pairDone;

  // Last slot of a pair arrives when the low counter bits are all ones.
  assign pairDone = &phaseCnt[PHASE_W-1:0];

  always_ff @(posedge srcClk) begin
    if (srcRst) phaseCnt <= '0;
    else        phaseCnt <= phaseCnt + CNT_W'(1);
  end

  // Lead shift register holding the earlier pixels of the pair being built.
  for (genvar g = 0; g < LEAD_N; g++) begin : g_lead
    if (g == 0) begin : g_head
      always_ff @(posedge srcClk) begin
        if (srcRst) leadStage[g] <= '0;
        else        leadStage[g] <= pixIn;
      end
    end else begin : g_tail
      always_ff @(posedge srcClk) begin
        if (srcRst) leadStage[g] <= '0;
        else        leadStage[g] <= leadStage[g-1];
      end
    end
  end

  // Slot 0 is the oldest pixel; the newest goes in the top slot straight from the input.
  for (genvar k = 0; k < PAIR_N; k++) begin : g_slot
    if (k == PAIR_N - 1) begin : g_new
      assign pairNext[k*PIX_W +: PIX_W] = pixIn;
    end else begin : g_old
      assign pairNext[k*PIX_W +: PIX_W] = leadStage[LEAD_N-1-k];
    end
  end

  always_ff @(posedge srcClk) begin
    if (srcRst)        pairOut <= '0;
    else if (pairDone) pairOut <= pairNext;
  end

  assign pairToggle = phaseCnt[CNT_W-1];

  // R3: the toggle holds for at least one more source cycle after each change.
  p_toggle_hold_r3: assert property (@(posedge srcClk) disable iff (srcRst)
    !$stable(pairToggle) |=> $stable(pairToggle));

  // R3: the pair register never moves without a toggle change beside it.
  p_pair_with_toggle_r3: assert property (@(posedge srcClk) disable iff (srcRst)
    !$stable(pairOut) |-> !$stable(pairToggle));

endmodule

// File: rtl/pxcDstCtl.sv
`timescale 1ns/1ps
module pxcDstCtl
  import pxc_pkg::*;
(
  input  logic      dstClk,
  input  logic      dstRst,
  input  logic      toggleIn,
  output dstStrobeT strobe
);

  logic      syncFf;
  edgeStateT edgeSt;
  edgeStateT edgeNext;

  always_ff @(posedge dstClk) begin
    if (dstRst) syncFf <= 1'b0;
    else        syncFf <= toggleIn;
  end

  // Only the next value of bit 0 depends on syncFf.
  always_comb begin
    edgeNext = edgeSt;
    unique case (edgeSt)
      ST_WAIT_HI:  edgeNext = syncFf  ? ST_PULSE_UP : ST_WAIT_HI;
      ST_PULSE_UP: edgeNext = ST_WAIT_LO;
      ST_WAIT_LO:  edgeNext = !syncFf ? ST_PULSE_DN : ST_WAIT_LO;
      ST_PULSE_DN: edgeNext = ST_WAIT_HI;
      default:     edgeNext = ST_WAIT_HI;
    endcase
  end

  always_ff @(posedge dstClk) begin
    if (dstRst) edgeSt <= ST_WAIT_HI;
    else        edgeSt <= edgeNext;
  end

  assign strobe.wrPulse = edgeSt[0];

  // R3: a rising-change pulse is always followed by waiting for the low level.
  p_up_step_r3: assert property (@(posedge dstClk) disable iff (dstRst)
    edgeSt == ST_PULSE_UP |=> edgeSt == ST_WAIT_LO);

  // R3: a falling-change pulse is always followed by waiting for the high level.
  p_dn_step_r3: assert property (@(posedge dstClk) disable iff (dstRst)
    edgeSt == ST_PULSE_DN |=> edgeSt == ST_WAIT_HI);

  // R3: leaving a wait state needs the synchronized toggle at the opposite level.
  p_wait_hi_exit_r3: assert property (@(posedge dstClk) disable iff (dstRst)
    (edgeSt == ST_WAIT_HI && !syncFf) |=> edgeSt == ST_WAIT_HI);

endmodule

// File: rtl/pxcDstPath.sv
`timescale 1ns/1ps
module pxcDstPath
  import pxc_pkg::*;
#(
  parameter int PAIR_W = 16
) (
  input  logic              dstClk,
  input  logic              dstRst,
  input  dstStrobeT         strobe,
  input  logic [PAIR_W-1:0] pairIn,
  output logic [PAIR_W-1:0] dstPair,
  output logic              dstValid
);

  always_ff @(posedge dstClk) begin
    if (dstRst) begin
      dstPair  <= '0;
      dstValid <= 1'b0;
    end else begin
      if (strobe.wrPulse) dstPair <= pairIn;
      dstValid <= strobe.wrPulse;
    end
  end

  // R4: valid never lasts two cycles.
  p_single_cycle_r4: assert property (@(posedge dstClk) disable iff (dstRst)
    dstValid |=> !dstValid);

  // R5: the output pair moves only together with valid.
  p_hold_r5: assert property (@(posedge dstClk) disable iff (dstRst)
    !$stable(dstPair) |-> dstValid);

endmodule

// File: rtl/pxcPairCross.sv
`timescale 1ns/1ps
module pxcPairCross
  import pxc_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic                 srcClk,
  input  logic                 srcRst,
  input  logic [PIX_W-1:0]     srcPix,
  input  logic                 dstClk,
  input  logic                 dstRst,
  output logic [2*PIX_W-1:0]   dstPair,
  output logic                 dstValid
);

  localparam int PAIR_N = 2;
  localparam int PAIR_W = PAIR_N * PIX_W;

  logic [PAIR_W-1:0] srcPairReg;
  logic              srcToggle;
  dstStrobeT         dstStrobe;

  pxcSrcStage #(.PIX_W(PIX_W), .PAIR_N(PAIR_N)) uSrc (
    .srcClk     (srcClk),
    .srcRst     (srcRst),
    .pixIn      (srcPix),
    .pairOut    (srcPairReg),
    .pairToggle (srcToggle)
  );

  pxcDstCtl uCtl (
    .dstClk   (dstClk),
    .dstRst   (dstRst),
    .toggleIn (srcToggle),
    .strobe   (dstStrobe)
  );

  pxcDstPath #(.PAIR_W(PAIR_W)) uPath (
    .dstClk   (dstClk),
    .dstRst   (dstRst),
    .strobe   (dstStrobe),
    .pairIn   (srcPairReg),
    .dstPair  (dstPair),
    .dstValid (dstValid)
  );

endmodule

// File: tb/tb_pxcPairCross.sv
`timescale 1ns/1ps
module tb_pxcPairCross;

  localparam int      PIX_W      = 8;
  localparam realtime CLK_PERIOD = 10.0;
  localparam realtime SRC_HALF   = 18.5;
  localparam int      TAB_N      = 16;
  localparam logic [PIX_W-1:0] PIX_TAB [TAB_N] = '{
    8'h00, 8'hFF, 8'hAA, 8'h55, 8'h01, 8'h80, 8'h7F, 8'hFE,
    8'h0F, 8'hF0, 8'h3C, 8'hC3, 8'h11, 8'h11, 8'hFF, 8'h00};

  logic srcClk, srcRst, dstClk, dstRst;
  logic [PIX_W-1:0]   srcPix;
  logic [2*PIX_W-1:0] dstPair;
  logic               dstValid;

  int checks = 0;
  int fails = 0;
  int delivered = 0;
  bit finished = 0;

  logic [2*PIX_W-1:0] expQ[$];
  realtime            timeQ[$];

  pxcPairCross #(.PIX_W(PIX_W)) dut (
    .srcClk(srcClk), .srcRst(srcRst), .srcPix(srcPix),
    .dstClk(dstClk), .dstRst(dstRst),
    .dstPair(dstPair), .dstValid(dstValid));

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic endRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    dstClk = 0;
    forever #(CLK_PERIOD / 2.0) dstClk = ~dstClk;
  end

  // Random start offset that keeps source edges off destination edges.
  initial begin
    int offPs;
    srcClk = 0;
    offPs = 137 + int'($urandom % 300);
    #(offPs / 1000.0);
    forever #(SRC_HALF) srcClk = ~srcClk;
  end

  // Source driver and pair model (R2): table first, then incrementing values.
  initial begin
    int n = 0;
    bit have = 0;
    logic [PIX_W-1:0] prevPix = '0;
    srcPix = '0;
    forever begin
      @(negedge srcClk);
      srcPix = (n < TAB_N) ? PIX_TAB[n] : PIX_W'(n);
      @(posedge srcClk);
      #1;
      if (srcRst) begin
        have = 0;
      end else begin
        n++;
        if (have) begin
          expQ.push_back({srcPix, prevPix});
          timeQ.push_back($realtime - 1.0);
          have = 0;
        end else begin
          prevPix = srcPix;
          have = 1;
        end
      end
    end
  end

  // Destination monitor.
  initial begin
    bit prevValid = 0;
    logic [2*PIX_W-1:0] prevPair = '0;
    forever begin
      @(negedge dstClk);
      if (dstRst) begin
        prevValid = 0;
        prevPair  = dstPair;
      end else begin
        if (dstValid) begin
          check(!prevValid, "R4 valid in consecutive cycles", 32'(prevValid), 0);
          if (expQ.size() == 0) begin
            check(0, "R3 unexpected pair", 32'(dstPair), 0);
          end else begin
            logic [2*PIX_W-1:0] e;
            realtime dt;
            e  = expQ.pop_front();
            dt = $realtime - timeQ.pop_front();
            check(dstPair == e, "R2/R3 pair value or order", 32'(dstPair), 32'(e));
            check(dt > 2.5 * CLK_PERIOD && dt < 3.5 * CLK_PERIOD,
                  "R6 latency in ps", 32'(int'(dt * 1000.0)), 32'(int'(3.0 * CLK_PERIOD * 1000.0)));
          end
          delivered++;
        end else begin
          check(dstPair == prevPair, "R5 pair moved without valid", 32'(dstPair), 32'(prevPair));
        end
        prevValid = dstValid;
        prevPair  = dstPair;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", delivered, 100);
    endRun();
  end

  initial begin
    srcRst = 1;
    dstRst = 1;
    repeat (6) @(negedge srcClk);
    // R1: destination out of reset, source still held.
    @(negedge dstClk);
    dstRst = 0;
    repeat (4) begin
      @(negedge dstClk);
      check(dstValid == 0, "R1 valid after reset", 32'(dstValid), 0);
      check(dstPair == 0, "R1 pair after reset", 32'(dstPair), 0);
    end
    @(negedge srcClk);
    srcRst = 0;
    wait (delivered >= 60);

    // R7: reset both domains mid-stream.
    @(negedge srcClk);
    srcRst = 1;
    dstRst = 1;
    expQ.delete();
    timeQ.delete();
    repeat (8) @(negedge srcClk);
    @(negedge dstClk);
    check(dstValid == 0, "R7 valid during reset", 32'(dstValid), 0);
    check(dstPair == 0, "R7 pair cleared", 32'(dstPair), 0);
    dstRst = 0;
    repeat (6) begin
      @(negedge dstClk);
      check(dstValid == 0, "R7 stale pulse after reset", 32'(dstValid), 0);
    end
    @(negedge srcClk);
    srcRst = 0;
    wait (delivered >= 100);
    srcRst = 1;
    repeat (20) @(negedge dstClk);
    check(expQ.size() == 0, "R3 pairs left undelivered", 32'(expQ.size()), 0);
    endRun();
  end

endmodule